// File: doc/BRIEF.md
# I2C Slave Interface with Switchable Acknowledge

This block is the slave side of an I2C serial bus port. Both bus lines come in through a synchronizer and are edge-detected on the system clock. The block recognizes START and STOP conditions. It then shifts in a 7-bit address and the read/write flag. The address is checked against a programmable own address and against the general call address (all zeros).

When the address matches, the block moves data in one of two directions:
- It receives bytes from the master and presents them on a parallel output.
- It transmits bytes that the host supplies one at a time.

After every byte the block raises a service request. It holds SCL low until the host loads the next transmit byte or clears the request.

A mode input chooses how the ninth clock is handled:
- With acknowledge mode set, the ninth clock of every byte is counted as an acknowledge slot.
- With it cleared, bytes are eight clocks long and no acknowledge slot exists.

Status outputs report the role, bus busy, request state, address hit, general call and the last bit received.

Top module: `i2c_ack_slave`

## Requirements
- R1: After reset, bus_busy=0, req_n=1, addr_hit=0, gen_call=0, tx_role=0, and both open-drain enables (sda_oe, scl_oe) are 0.
- R2: A START (SDA falls while SCL is high) sets bus_busy and clears addr_hit and gen_call. A STOP (SDA rises while SCL is high) clears bus_busy and releases SDA and SCL.
- R3: In acknowledge mode, when the first byte's upper seven bits (sent MSB first) equal own_addr, the slave pulls SDA low during the ninth clock and sets addr_hit=1. The eighth bit (1 = read) sets tx_role.
- R4: Address 0 (general call) is acknowledged and sets addr_hit=1, gen_call=1 and tx_role=0. The data bytes that follow are received and acknowledged.
- R5: When the address matches neither own_addr nor 0, SDA is never driven and no request is raised. Every later byte up to the next START is ignored, and rx_data keeps its value.
- R6: As a receiver in acknowledge mode, each data byte is acknowledged low. rx_data shows the byte (first bit in is the MSB), and last_bit equals the byte's final bit.
- R7: As a transmitter, the loaded byte goes out MSB first. SDA is released during the acknowledge slot, and last_bit captures the master's acknowledge (0 = ACK, 1 = NACK).
- R8: At the end of each byte of a matched transfer, req_n goes to 0 and scl_oe to 1. A pulse on tx_wr or req_clr returns req_n to 1 and releases SCL.
- R9: With ack_mode=0, a byte ends after eight clocks and raises the request there. A receiver never drives SDA, and a transmitter sends consecutive bytes with no acknowledge clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | SCL pin level |
| sda_i | input | 1 | SDA pin level |
| scl_oe | output | 1 | 1 = pull SCL low (clock stretch) |
| sda_oe | output | 1 | 1 = pull SDA low |
| own_addr | input | ADDR_W | Own slave address |
| ack_mode | input | 1 | 1 = acknowledge slot counted, 0 = no acknowledge slot |
| tx_data | input | DATA_W | Byte to transmit |
| tx_wr | input | 1 | Load tx_data and release the request |
| req_clr | input | 1 | Release the request without loading data |
| rx_data | output | DATA_W | Last received data byte |
| tx_role | output | 1 | 1 = transmitter, 0 = receiver |
| bus_busy | output | 1 | 1 = between START and STOP |
| req_n | output | 1 | 0 = service requested, 1 = released |
| addr_hit | output | 1 | Own address or general call matched |
| gen_call | output | 1 | General call matched |
| last_bit | output | 1 | Last bit received from the bus |

## Verification
The bench builds the block with SYNC_STAGES=3 and the default 8-bit data and 7-bit address widths. The deeper synchronizer adds latency between a pin edge and the slave's response. The bench's bus master, which runs eight system clocks per quarter bit, checks that this latency still falls inside the SCL-low half of each bit. The fixed widths make every address and byte pattern, including the all-zero general call, directly drivable. With them, both the ninth-clock and eight-clock byte framings can be run back to back.

// File: rtl/i2cs_pkg.sv
package i2cs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE   = 2'd0,
      ST_ACTIVE = 2'd1,
      ST_IGNORE = 2'd2
   } slv_state_e;
endpackage

// File: rtl/i2cs_sync.sv
// Pin synchronizer and bus condition detector.
module i2cs_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic scl_i,
   input  logic sda_i,
   output logic sda_s,
   output logic scl_rise,
   output logic scl_fall,
   output logic start_det,
   output logic stop_det
);
   if (STAGES < 2) begin : g_bad_stages
      $error("i2cs_sync: STAGES must be at least 2");
   end

   logic [1:0] pipe [STAGES];
   logic [1:0] prev;
   logic [1:0] cur;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe[0] <= 2'b11;
      else        pipe[0] <= {scl_i, sda_i};
   end

   for (genvar k = 1; k < STAGES; k++) begin : g_stage
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) pipe[k] <= 2'b11;
         else        pipe[k] <= pipe[k-1];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev <= 2'b11;
      else        prev <= cur;
   end

   assign cur       = pipe[STAGES-1];
   assign sda_s     = cur[0];
   assign scl_rise  =  cur[1] & ~prev[1];
   assign scl_fall  = ~cur[1] &  prev[1];
   assign start_det =  cur[1] &  prev[1] &  prev[0] & ~cur[0];
   assign stop_det  =  cur[1] &  prev[1] & ~prev[0] &  cur[0];
endmodule

// File: rtl/i2cs_core.sv
// Byte framing, address decode, acknowledge and request handling.
module i2cs_core
   import i2cs_pkg::*;
#(
   parameter int unsigned DATA_W = 8,
   parameter int unsigned ADDR_W = 7
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_rise,
   input  logic              scl_fall,
   input  logic              sda_s,
   input  logic              start_det,
   input  logic              stop_det,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ack_mode,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              req_clr,
   output logic              drive_sda,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_role,
   output logic              bus_busy,
   output logic              req_n,
   output logic              addr_hit,
   output logic              gen_call,
   output logic              last_bit
);
   localparam int unsigned CNT_W = $clog2(DATA_W + 2);
   localparam logic [CNT_W-1:0] N_LAST = CNT_W'(DATA_W - 1);
   localparam logic [CNT_W-1:0] N_BITS = CNT_W'(DATA_W);
   localparam logic [CNT_W-1:0] N_ACK  = CNT_W'(DATA_W + 1);
   localparam logic [CNT_W-1:0] C_ONE  = CNT_W'(1);

   if (DATA_W != ADDR_W + 1) begin : g_bad_width
      $error("i2cs_core: DATA_W must equal ADDR_W + 1");
   end

   slv_state_e        state;
   logic [CNT_W-1:0]  bcnt;
   logic [DATA_W-2:0] sh;
   logic [DATA_W-1:0] tx_sh;
   logic              is_addr;
   logic [DATA_W-1:0] byte_in;
   logic [ADDR_W-1:0] addr_in;
   logic              own_match;
   logic              gc_match;

   assign byte_in   = {sh, sda_s};
   assign addr_in   = byte_in[DATA_W-1:1];
   assign own_match = (addr_in == own_addr);
   assign gc_match  = (addr_in == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_IDLE;
         bcnt      <= '0;
         sh        <= '0;
         tx_sh     <= '0;
         is_addr   <= 1'b0;
         drive_sda <= 1'b0;
         rx_data   <= '0;
         tx_role   <= 1'b0;
         bus_busy  <= 1'b0;
         req_n     <= 1'b1;
         addr_hit  <= 1'b0;
         gen_call  <= 1'b0;
         last_bit  <= 1'b0;
      end else if (start_det) begin
         state     <= ST_ACTIVE;
         bus_busy  <= 1'b1;
         addr_hit  <= 1'b0;
         gen_call  <= 1'b0;
         tx_role   <= 1'b0;
         bcnt      <= '0;
         drive_sda <= 1'b0;
         is_addr   <= 1'b1;
         req_n     <= 1'b1;
      end else if (stop_det) begin
         state     <= ST_IDLE;
         bus_busy  <= 1'b0;
         drive_sda <= 1'b0;
         req_n     <= 1'b1;
         bcnt      <= '0;
         is_addr   <= 1'b0;
      end else begin
         if (tx_wr || req_clr) req_n <= 1'b1;
         if (tx_wr && state == ST_ACTIVE && tx_role && !is_addr) begin
            tx_sh     <= tx_data;
            drive_sda <= ~tx_data[DATA_W-1];
         end
         if (state == ST_ACTIVE && scl_rise) begin
            bcnt <= bcnt + C_ONE;
            if (bcnt < N_BITS) begin
               sh <= byte_in[DATA_W-2:0];
               if (is_addr || !tx_role) last_bit <= sda_s;
               if (bcnt == N_LAST) begin
                  if (is_addr) begin
                     if (own_match || gc_match) begin
                        addr_hit <= 1'b1;
                        gen_call <= gc_match;
                        tx_role  <= byte_in[0] & ~gc_match;
                     end else begin
                        state <= ST_IGNORE;
                     end
                  end else if (!tx_role) begin
                     rx_data <= byte_in;
                  end
               end
            end else if (tx_role && !is_addr) begin
               last_bit <= sda_s;
            end
         end
         if (state == ST_ACTIVE && scl_fall) begin
            if (bcnt == N_BITS && ack_mode) begin
               drive_sda <= is_addr | ~tx_role;
            end else if (bcnt == N_BITS || bcnt == N_ACK) begin
               drive_sda <= 1'b0;
               bcnt      <= '0;
               req_n     <= 1'b0;
               is_addr   <= 1'b0;
            end else if (bcnt != '0 && tx_role && !is_addr) begin
               tx_sh     <= tx_sh << 1;
               drive_sda <= ~tx_sh[DATA_W-2];
            end
         end
      end
   end
endmodule

// File: rtl/i2c_ack_slave.sv
module i2c_ack_slave #(
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned ADDR_W      = 7,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              scl_i,
   input  logic              sda_i,
   output logic              scl_oe,
   output logic              sda_oe,
   input  logic [ADDR_W-1:0] own_addr,
   input  logic              ack_mode,
   input  logic [DATA_W-1:0] tx_data,
   input  logic              tx_wr,
   input  logic              req_clr,
   output logic [DATA_W-1:0] rx_data,
   output logic              tx_role,
   output logic              bus_busy,
   output logic              req_n,
   output logic              addr_hit,
   output logic              gen_call,
   output logic              last_bit
);
   logic sda_s, scl_rise, scl_fall, start_det, stop_det;

   i2cs_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_i     (scl_i),
      .sda_i     (sda_i),
      .sda_s     (sda_s),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .start_det (start_det),
      .stop_det  (stop_det)
   );

   i2cs_core #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_core (
      .clk       (clk),
      .rst_n     (rst_n),
      .scl_rise  (scl_rise),
      .scl_fall  (scl_fall),
      .sda_s     (sda_s),
      .start_det (start_det),
      .stop_det  (stop_det),
      .own_addr  (own_addr),
      .ack_mode  (ack_mode),
      .tx_data   (tx_data),
      .tx_wr     (tx_wr),
      .req_clr   (req_clr),
      .drive_sda (sda_oe),
      .rx_data   (rx_data),
      .tx_role   (tx_role),
      .bus_busy  (bus_busy),
      .req_n     (req_n),
      .addr_hit  (addr_hit),
      .gen_call  (gen_call),
      .last_bit  (last_bit)
   );

   assign scl_oe = ~req_n;
endmodule

// File: rtl/i2cs_chk.sv
module i2cs_chk (
   input logic clk,
   input logic rst_n,
   input logic ack_mode,
   input logic sda_oe,
   input logic scl_oe,
   input logic tx_role,
   input logic bus_busy,
   input logic req_n,
   input logic addr_hit,
   input logic gen_call
);
   // R8: a request can only be raised inside a transfer
   p_req_in_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(req_n) |-> bus_busy);

   // R5: SDA is only pulled after a matched address
   p_drive_matched_r5: assert property (@(posedge clk) disable iff (!rst_n)
      sda_oe |-> addr_hit);

   // R4: a general call is a matched receive transfer
   p_gc_receiver_r4: assert property (@(posedge clk) disable iff (!rst_n)
      gen_call |-> (addr_hit && !tx_role));

   // R2: with the bus free both lines are released
   p_idle_released_r2: assert property (@(posedge clk) disable iff (!rst_n)
      !bus_busy |-> (!sda_oe && !scl_oe));

   // R9: without acknowledge slots only a transmitter pulls SDA
   p_noack_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (!ack_mode && sda_oe) |-> tx_role);
endmodule

bind i2c_ack_slave i2cs_chk u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .ack_mode (ack_mode),
   .sda_oe   (sda_oe),
   .scl_oe   (scl_oe),
   .tx_role  (tx_role),
   .bus_busy (bus_busy),
   .req_n    (req_n),
   .addr_hit (addr_hit),
   .gen_call (gen_call)
);

// File: tb/test_i2c_ack_slave.sv
module test_i2c_ack_slave;
   localparam int Q = 8;
   localparam logic [6:0] OWN = 7'h52;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic scl_m = 1'b1, sda_m = 1'b1;
   logic ack_mode = 1'b1;
   logic [7:0] tx_data = 8'h00;
   logic tx_wr = 1'b0, req_clr = 1'b0;
   logic scl_oe, sda_oe;
   logic [7:0] rx_data;
   logic tx_role, bus_busy, req_n, addr_hit, gen_call, last_bit;
   logic scl_line, sda_line;
   int n_chk = 0, n_fail = 0, oe_seen = 0;
   bit mon_en = 1'b0, done = 1'b0;

   always #5 clk = ~clk;

   assign scl_line = scl_m & ~scl_oe;
   assign sda_line = sda_m & ~sda_oe;

   i2c_ack_slave #(.DATA_W(8), .ADDR_W(7), .SYNC_STAGES(3)) i_i2c_ack_slave (
      .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
      .scl_oe(scl_oe), .sda_oe(sda_oe), .own_addr(OWN), .ack_mode(ack_mode),
      .tx_data(tx_data), .tx_wr(tx_wr), .req_clr(req_clr), .rx_data(rx_data),
      .tx_role(tx_role), .bus_busy(bus_busy), .req_n(req_n),
      .addr_hit(addr_hit), .gen_call(gen_call), .last_bit(last_bit)
   );

   always @(negedge clk) if (mon_en && sda_oe) oe_seen++;

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic wq();
      repeat (Q) @(negedge clk);
   endtask

   task automatic clk_bit(input logic b, output logic s);
      sda_m = b; wq();
      scl_m = 1'b1;
      wait (scl_line === 1'b1);
      @(negedge clk); wq();
      s = sda_line; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic m_start();
      sda_m = 1'b1; scl_m = 1'b1; wq();
      sda_m = 1'b0; wq();
      scl_m = 1'b0; wq();
   endtask

   task automatic m_stop();
      sda_m = 1'b0; wq();
      scl_m = 1'b1;
      wait (scl_line === 1'b1);
      wq(); sda_m = 1'b1; wq(); wq();
   endtask

   task automatic m_write(input logic [7:0] d, output logic ack);
      logic s;
      for (int i = 7; i >= 0; i--) clk_bit(d[i], s);
      ack = 1'b1;
      if (ack_mode) clk_bit(1'b1, ack);
   endtask

   task automatic m_read(input logic nack, output logic [7:0] d);
      logic s;
      for (int i = 7; i >= 0; i--) begin
         clk_bit(1'b1, s);
         d[i] = s;
      end
      if (ack_mode) clk_bit(nack, s);
   endtask

   task automatic h_release();
      @(negedge clk) req_clr = 1'b1;
      @(negedge clk) req_clr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   task automatic h_load(input logic [7:0] d);
      @(negedge clk) begin tx_data = d; tx_wr = 1'b1; end
      @(negedge clk) tx_wr = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(negedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog R1 actual=hung expected=finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

   initial begin
      logic a;
      logic [7:0] d;
      repeat (4) @(negedge clk);
      check("R1 bus_busy", bus_busy, 0);
      check("R1 req_n", req_n, 1);
      check("R1 addr_hit", addr_hit, 0);
      check("R1 gen_call", gen_call, 0);
      check("R1 tx_role", tx_role, 0);
      check("R1 oe", {sda_oe, scl_oe}, 0);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);

      // acknowledge mode, write two bytes
      m_start();
      check("R2 busy after start", bus_busy, 1);
      m_write({OWN, 1'b0}, a);
      check("R3 address ack", a, 0);
      check("R3 addr_hit", addr_hit, 1);
      check("R3 tx_role write", tx_role, 0);
      check("R3 gen_call", gen_call, 0);
      check("R8 request", req_n, 0);
      check("R8 scl held", scl_oe, 1);
      h_release();
      check("R8 released req", req_n, 1);
      check("R8 scl free", scl_oe, 0);
      m_write(8'hA5, a);
      check("R6 data ack", a, 0);
      check("R6 rx_data", rx_data, 8'hA5);
      check("R6 last_bit", last_bit, 1);
      h_release();
      m_write(8'h3C, a);
      check("R6 data ack 2", a, 0);
      check("R6 rx_data 2", rx_data, 8'h3C);
      check("R6 last_bit 2", last_bit, 0);
      h_release();
      m_stop();
      check("R2 busy after stop", bus_busy, 0);
      check("R2 lines released", {sda_oe, scl_oe}, 0);

      // acknowledge mode, read two bytes
      m_start();
      check("R2 addr_hit cleared", addr_hit, 0);
      m_write({OWN, 1'b1}, a);
      check("R3 read ack", a, 0);
      check("R3 tx_role read", tx_role, 1);
      h_load(8'h96);
      m_read(1'b0, d);
      check("R7 tx byte", d, 8'h96);
      check("R7 master ack", last_bit, 0);
      check("R8 request after tx", req_n, 0);
      h_load(8'hC3);
      m_read(1'b1, d);
      check("R7 tx byte 2", d, 8'hC3);
      check("R7 master nack", last_bit, 1);
      h_release();
      m_stop();

      // general call
      m_start();
      m_write(8'h00, a);
      check("R4 gc ack", a, 0);
      check("R4 addr_hit", addr_hit, 1);
      check("R4 gen_call", gen_call, 1);
      check("R4 receiver", tx_role, 0);
      h_release();
      m_write(8'h5A, a);
      check("R4 gc data ack", a, 0);
      check("R4 gc rx_data", rx_data, 8'h5A);
      h_release();
      m_stop();

      // foreign address
      m_start();
      check("R2 gen_call cleared", gen_call, 0);
      m_write({7'h11, 1'b0}, a);
      check("R5 no address ack", a, 1);
      check("R5 addr_hit", addr_hit, 0);
      check("R5 no request", {req_n, scl_oe}, 2'b10);
      m_write(8'hFF, a);
      check("R5 no data ack", a, 1);
      check("R5 rx_data kept", rx_data, 8'h5A);
      check("R5 no request 2", req_n, 1);
      m_stop();

      // no acknowledge slot, write
      ack_mode = 1'b0;
      oe_seen = 0; mon_en = 1'b1;
      m_start();
      m_write({OWN, 1'b0}, a);
      check("R9 addr_hit", addr_hit, 1);
      check("R9 request after 8 clocks", req_n, 0);
      h_release();
      m_write(8'h81, a);
      check("R9 rx_data", rx_data, 8'h81);
      check("R9 last_bit", last_bit, 1);
      check("R9 request", req_n, 0);
      h_release();
      m_stop();
      mon_en = 1'b0;
      check("R9 receiver never drives", oe_seen, 0);

      // no acknowledge slot, read
      m_start();
      m_write({OWN, 1'b1}, a);
      check("R9 tx_role", tx_role, 1);
      h_load(8'h4E);
      m_read(1'b1, d);
      check("R9 tx byte", d, 8'h4E);
      check("R9 tx request", req_n, 0);
      h_load(8'hB1);
      m_read(1'b1, d);
      check("R9 tx byte 2", d, 8'hB1);
      h_release();
      m_stop();
      check("R2 final idle", bus_busy, 0);

      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule